// File: doc/BRIEF.md
# Multicycle Accumulator Processor

This block is a small processor with one accumulator, 16-bit words and a 4096-word memory held inside it. Each instruction passes through a fixed series of clocked register transfers between five registers: the program counter, the instruction register, the memory address register, the memory buffer register and the accumulator. The series is: fetch the word, decode it, read the operand if the instruction needs one, execute, and write the result back if the instruction needs that. The base set covers loading, storing, adding, subtracting and clearing the accumulator, plus a jump, a conditional skip and a halt. Three further instructions work directly on memory or on the program counter. The first increments a memory word in place. The second adds a memory word to the program counter. The third zeroes a memory word only when the accumulator is positive.

A testbench or an enclosing system fills the memory through a load port while reset is held. Execution starts at address 0 when reset is released and continues until a halt instruction. After the halt, the block freezes, and its final state can be read out. The program counter and the accumulator appear on ports, and any memory word can be read at any time through a peek port.

Top module: `accCpu`

## Requirements
- R1: While `rstN` is low, `pcOut` and `acOut` are 0 and `halted` is 0. Driving `loadEn` high during reset writes `loadData` to the word at `loadAddr`. `peekData` always shows the word at `peekAddr`.
- R2: An instruction word has its opcode in bits 15:12 and an address X in bits 11:0. The codes are 1 load, 2 store, 3 add, 4 subtract, 7 halt, 8 skip, 9 jump, A clear, B increment-memory, C add-to-PC and D clear-if-positive. Every other code does nothing except advance the PC by one.
- R3: Load sets AC to M[X]. Add sets AC to AC+M[X], and subtract sets AC to AC-M[X], both modulo 2^16.
- R4: Store writes AC to M[X]. Clear sets AC to 0.
- R5: Jump sets PC to X.
- R6: Increment-memory writes M[X]+1 (modulo 2^16) back to M[X] and leaves AC unchanged.
- R7: Add-to-PC sets PC to the already incremented PC plus bits 11:0 of M[X], modulo 4096.
- R8: Clear-if-positive writes 0 to M[X] only when AC is nonzero and AC bit 15 is 0. Otherwise memory is unchanged.
- R9: Halt raises `halted`, leaves PC at the halt's address plus one, and afterwards no register or memory word changes.
- R10: For the skip instruction, bits 11:10 select the condition: 00 means AC<0, 01 means AC=0, 10 means AC>0, and 11 means never. When the condition holds, the PC advances one extra word.
- R11: The number of clock edges from the release of reset until `halted` is high equals the sum of the per-instruction costs. The costs are 4 for a halt or an unused code. They are 5 for clear, jump, skip and a clear-if-positive that does not write. They are 6 for load, add, subtract, store, add-to-PC and a clear-if-positive that writes. They are 7 for increment-memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Memory write strobe for preloading (use only during reset) |
| loadAddr | input | 12 | Preload address |
| loadData | input | 16 | Preload data |
| peekAddr | input | 12 | Read-out address |
| peekData | output | 16 | Memory word at `peekAddr` |
| pcOut | output | 12 | Program counter |
| acOut | output | 16 | Accumulator |
| halted | output | 1 | High once a halt has executed |

## Verification
The embedded properties check these rules on every cycle: once halted, the block stays frozen; at most one source drives the program counter at a time; a clear-if-positive never writes memory unless the accumulator is positive; a store writes exactly the accumulator value; and no memory write changes the accumulator. Only the bench's programs can show the arithmetic results, the skip conditions, the wrap of the program counter on jumps and on add-to-PC, the per-instruction cycle costs and the final memory contents. It checks these by comparing each run with an instruction-level model. The programs combine random instruction mixes with directed runs around the accumulator values 0, 0x8000, 0x0001, 0x7FFF and 0xFFFF.

// File: rtl/accCpuPkg.sv
package accCpuPkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned OpW = 4;

  localparam logic [OpW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OpW-1:0] OP_STORE = 4'h2;
  localparam logic [OpW-1:0] OP_ADD   = 4'h3;
  localparam logic [OpW-1:0] OP_SUB   = 4'h4;
  localparam logic [OpW-1:0] OP_HALT  = 4'h7;
  localparam logic [OpW-1:0] OP_SKIP  = 4'h8;
  localparam logic [OpW-1:0] OP_JUMP  = 4'h9;
  localparam logic [OpW-1:0] OP_CLEAR = 4'hA;
  localparam logic [OpW-1:0] OP_INCM  = 4'hB;
  localparam logic [OpW-1:0] OP_ADDPC = 4'hC;
  localparam logic [OpW-1:0] OP_ZPOS  = 4'hD;

  typedef enum logic [2:0] {
    sFetchAddr,
    sFetchRead,
    sFetchLatch,
    sDecode,
    sOperand,
    sExecute,
    sStore,
    sHalt
  } stateT;

  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic mbrFromMem;
    logic mbrFromAc;
    logic mbrInc;
    logic mbrClear;
    logic irFromMbr;
    logic pcInc;
    logic pcFromIr;
    logic pcAddMbr;
    logic acFromMbr;
    logic acAdd;
    logic acSub;
    logic acClear;
    logic memWrite;
  } ctlT;
endpackage

// File: rtl/accCpuMem.sv
module accCpuMem #(
  parameter int unsigned WordW = 16,
  parameter int unsigned AddrW = 12
) (
  input  logic             clk,
  input  logic             loadEn,
  input  logic [AddrW-1:0] loadAddr,
  input  logic [WordW-1:0] loadData,
  input  logic             wrEn,
  input  logic [AddrW-1:0] cpuAddr,
  input  logic [WordW-1:0] wrData,
  output logic [WordW-1:0] rdData,
  input  logic [AddrW-1:0] peekAddr,
  output logic [WordW-1:0] peekData
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned Depth = 1 << AddrW;

  logic [WordW-1:0] memArr [Depth];

  // Preload port has priority; the sequencer never writes while reset holds it idle.
  always_ff @(posedge clk) begin
    if (loadEn) memArr[loadAddr] <= loadData;
    else if (wrEn) memArr[cpuAddr] <= wrData;
  end

  assign rdData   = memArr[cpuAddr];
  assign peekData = memArr[peekAddr];
endmodule

// File: rtl/accCpuDatapath.sv
module accCpuDatapath import accCpuPkg::*; #(
  parameter int unsigned WordW = 16,
  parameter int unsigned AddrW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlT              ctl,
  input  logic [WordW-1:0] memRd,
  output logic [AddrW-1:0] marOut,
  output logic [WordW-1:0] mbrOut,
  output logic [OpW-1:0]   irOp,
  output logic [1:0]       skipSel,
  output logic             acNeg,
  output logic             acZero,
  output logic [AddrW-1:0] pcOut,
  output logic [WordW-1:0] acOut
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [AddrW-1:0] PcOne   = AddrW'(1);
  localparam logic [WordW-1:0] WordOne = WordW'(1);

  logic [AddrW-1:0] pcQ, marQ;
  logic [WordW-1:0] irQ, mbrQ, acQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      marQ <= '0;
      irQ  <= '0;
      mbrQ <= '0;
      acQ  <= '0;
    end else begin
      if (ctl.marFromPc)      marQ <= pcQ;
      else if (ctl.marFromIr) marQ <= irQ[AddrW-1:0];

      if (ctl.mbrFromMem)     mbrQ <= memRd;
      else if (ctl.mbrFromAc) mbrQ <= acQ;
      else if (ctl.mbrInc)    mbrQ <= mbrQ + WordOne;
      else if (ctl.mbrClear)  mbrQ <= '0;

      if (ctl.irFromMbr) irQ <= mbrQ;

      if (ctl.pcInc)         pcQ <= pcQ + PcOne;
      else if (ctl.pcFromIr) pcQ <= irQ[AddrW-1:0];
      else if (ctl.pcAddMbr) pcQ <= pcQ + mbrQ[AddrW-1:0];

      if (ctl.acFromMbr)    acQ <= mbrQ;
      else if (ctl.acAdd)   acQ <= acQ + mbrQ;
      else if (ctl.acSub)   acQ <= acQ - mbrQ;
      else if (ctl.acClear) acQ <= '0;
    end
  end

  assign marOut  = marQ;
  assign mbrOut  = mbrQ;
  assign irOp    = irQ[WordW-1 -: OpW];
  assign skipSel = irQ[AddrW-1 -: 2];
  assign acNeg   = acQ[WordW-1];
  assign acZero  = (acQ == '0);
  assign pcOut   = pcQ;
  assign acOut   = acQ;

  // R8: a conditional clear only ever reaches memory with a positive accumulator
  p_zpos_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWrite && irOp == OP_ZPOS) |-> (!acQ[WordW-1] && acQ != '0));

  // R4: the store cycle writes the accumulator value
  p_store_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWrite && irOp == OP_STORE) |-> (mbrQ == acQ));

  // R6: a write-back never disturbs the accumulator
  p_ac_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWrite |=> $stable(acQ));
endmodule

// File: rtl/accCpuControl.sv
module accCpuControl import accCpuPkg::*; (
  input  logic           clk,
  input  logic           rstN,
  input  logic [OpW-1:0] irOp,
  input  logic [1:0]     skipSel,
  input  logic           acNeg,
  input  logic           acZero,
  output ctlT            ctl,
  output logic           halted
);
  timeunit 1ns;
  timeprecision 1ps;

  stateT stateQ, stateD;
  logic  acPos, skipHit, needRead, execOnly, needStore;

  always_comb begin
    acPos = !acNeg && !acZero;
    unique case (skipSel)
      2'b00:   skipHit = acNeg;
      2'b01:   skipHit = acZero;
      2'b10:   skipHit = acPos;
      default: skipHit = 1'b0;
    endcase
    needRead  = irOp inside {OP_LOAD, OP_ADD, OP_SUB, OP_INCM, OP_ADDPC};
    execOnly  = irOp inside {OP_STORE, OP_CLEAR, OP_JUMP, OP_SKIP, OP_ZPOS};
    needStore = (irOp == OP_STORE) || (irOp == OP_INCM) || (irOp == OP_ZPOS && acPos);
  end

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      sFetchAddr: begin
        ctl.marFromPc = 1'b1;
        stateD = sFetchRead;
      end
      sFetchRead: begin
        ctl.mbrFromMem = 1'b1;
        stateD = sFetchLatch;
      end
      sFetchLatch: begin
        ctl.irFromMbr = 1'b1;
        ctl.pcInc     = 1'b1;
        stateD = sDecode;
      end
      sDecode: begin
        ctl.marFromIr = 1'b1;
        if (irOp == OP_HALT) stateD = sHalt;
        else if (needRead)   stateD = sOperand;
        else if (execOnly)   stateD = sExecute;
        else                 stateD = sFetchAddr;
      end
      sOperand: begin
        ctl.mbrFromMem = 1'b1;
        stateD = sExecute;
      end
      sExecute: begin
        unique case (irOp)
          OP_LOAD:  ctl.acFromMbr = 1'b1;
          OP_ADD:   ctl.acAdd     = 1'b1;
          OP_SUB:   ctl.acSub     = 1'b1;
          OP_STORE: ctl.mbrFromAc = 1'b1;
          OP_CLEAR: ctl.acClear   = 1'b1;
          OP_JUMP:  ctl.pcFromIr  = 1'b1;
          OP_SKIP:  ctl.pcInc     = skipHit;
          OP_INCM:  ctl.mbrInc    = 1'b1;
          OP_ADDPC: ctl.pcAddMbr  = 1'b1;
          OP_ZPOS:  ctl.mbrClear  = acPos;
          default:  ;
        endcase
        stateD = needStore ? sStore : sFetchAddr;
      end
      sStore: begin
        ctl.memWrite = 1'b1;
        stateD = sFetchAddr;
      end
      default: stateD = sHalt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= sFetchAddr;
    else       stateQ <= stateD;
  end

  assign halted = (stateQ == sHalt);

  // R5: the program counter has at most one source in any cycle
  p_pc_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.pcInc, ctl.pcFromIr, ctl.pcAddMbr}));

  // R9: a decoded halt reaches the terminal state on the next edge
  p_halt_enter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == sDecode && irOp == OP_HALT) |=> halted);
endmodule

// File: rtl/accCpu.sv
module accCpu import accCpuPkg::*; #(
  parameter int unsigned WordW = 16,
  parameter int unsigned AddrW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [AddrW-1:0] loadAddr,
  input  logic [WordW-1:0] loadData,
  input  logic [AddrW-1:0] peekAddr,
  output logic [WordW-1:0] peekData,
  output logic [AddrW-1:0] pcOut,
  output logic [WordW-1:0] acOut,
  output logic             halted
);
  timeunit 1ns;
  timeprecision 1ps;

  ctlT              ctl;
  logic [WordW-1:0] memRd, mbrBus;
  logic [AddrW-1:0] marBus;
  logic [OpW-1:0]   irOp;
  logic [1:0]       skipSel;
  logic             acNeg, acZero;

  accCpuControl u_ctl (
    .clk(clk), .rstN(rstN), .irOp(irOp), .skipSel(skipSel),
    .acNeg(acNeg), .acZero(acZero), .ctl(ctl), .halted(halted)
  );

  accCpuDatapath #(.WordW(WordW), .AddrW(AddrW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRd(memRd),
    .marOut(marBus), .mbrOut(mbrBus), .irOp(irOp), .skipSel(skipSel),
    .acNeg(acNeg), .acZero(acZero), .pcOut(pcOut), .acOut(acOut)
  );

  accCpuMem #(.WordW(WordW), .AddrW(AddrW)) u_mem (
    .clk(clk), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .wrEn(ctl.memWrite), .cpuAddr(marBus), .wrData(mbrBus), .rdData(memRd),
    .peekAddr(peekAddr), .peekData(peekData)
  );

  // R9: once halted, the block is frozen and writes nothing
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcOut) && $stable(acOut) && !ctl.memWrite));
endmodule

// File: tb/tb_accCpu.sv
module tb_accCpu;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [11:0] loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [11:0] peekAddr = '0;
  logic [15:0] peekData;
  logic [11:0] pcOut;
  logic [15:0] acOut;
  logic        halted;

  int checks = 0;
  int failures = 0;

  logic [15:0] img [4096];
  logic [15:0] sim [4096];
  logic [15:0] expAc;
  logic [11:0] expPc;
  int          expCyc;

  always #2 clk = ~clk;

  accCpu dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .peekAddr(peekAddr), .peekData(peekData),
    .pcOut(pcOut), .acOut(acOut), .halted(halted)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #700000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] x);
    return {op, x};
  endfunction

  task automatic clearImg();
    for (int a = 0; a < 4096; a++) img[a] = 16'h7000;
    for (int a = 'h800; a < 'h810; a++) img[a] = 16'h0000;
  endtask

  // Instruction-level model of the requirements (R2..R11)
  task automatic refRun();
    logic [11:0] pc;
    logic [15:0] ac, w;
    logic [11:0] x;
    logic        hit;
    for (int a = 0; a < 4096; a++) sim[a] = img[a];
    pc = '0; ac = '0; expCyc = 0;
    for (int step = 0; step < 3000; step++) begin
      w = sim[pc]; x = w[11:0]; pc = pc + 12'd1;
      if (w[15:12] == 4'h7) begin expCyc += 4; break; end
      case (w[15:12])
        4'h1: begin ac = sim[x]; expCyc += 6; end
        4'h2: begin sim[x] = ac; expCyc += 6; end
        4'h3: begin ac = ac + sim[x]; expCyc += 6; end
        4'h4: begin ac = ac - sim[x]; expCyc += 6; end
        4'h8: begin
          case (x[11:10])
            2'b00: hit = ac[15];
            2'b01: hit = (ac == 0);
            2'b10: hit = !ac[15] && ac != 0;
            default: hit = 1'b0;
          endcase
          if (hit) pc = pc + 12'd1;
          expCyc += 5;
        end
        4'h9: begin pc = x; expCyc += 5; end
        4'hA: begin ac = '0; expCyc += 5; end
        4'hB: begin sim[x] = sim[x] + 16'd1; expCyc += 7; end
        4'hC: begin pc = pc + sim[x][11:0]; expCyc += 6; end
        4'hD: begin
          if (!ac[15] && ac != 0) begin sim[x] = '0; expCyc += 6; end
          else expCyc += 5;
        end
        default: expCyc += 4;
      endcase
    end
    expAc = ac; expPc = pc;
  endtask

  task automatic loadRange(input int lo, input int n);
    for (int a = lo; a < lo + n; a++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 12'(a); loadData = img[a];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runProg(input string req);
    int n;
    logic [15:0] holdAc;
    logic [11:0] holdPc;
    @(negedge clk);
    rstN = 1'b0;
    loadRange(0, 64);
    loadRange('h800, 16);
    loadRange('hFF0, 16);
    refRun();
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    while (n < 20000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted) break;
    end
    check("R9", "halted", {15'd0, halted}, 16'd1);
    check("R11", "cycles to halt", 16'(n), 16'(expCyc));
    check(req, "accumulator", acOut, expAc);
    check(req, "pc", {4'd0, pcOut}, {4'd0, expPc});
    for (int a = 'h800; a < 'h810; a++) begin
      peekAddr = 12'(a);
      #1;
      check(req, $sformatf("mem[%h]", a), peekData, sim[a]);
    end
    holdAc = acOut; holdPc = pcOut;
    repeat (8) @(negedge clk);
    check("R9", "frozen ac", acOut, holdAc);
    check("R9", "frozen pc", {4'd0, pcOut}, {4'd0, holdPc});
    peekAddr = 12'h800;
    #1;
    check("R9", "frozen mem", peekData, sim['h800]);
  endtask

  function automatic logic [15:0] pickData();
    case ($urandom_range(0, 5))
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      4: return 16'h7FFF;
      default: return 16'($urandom());
    endcase
  endfunction

  task automatic genRandom();
    logic [11:0] x;
    logic [3:0]  nopCodes [5];
    nopCodes[0] = 4'h0; nopCodes[1] = 4'h5; nopCodes[2] = 4'h6;
    nopCodes[3] = 4'hE; nopCodes[4] = 4'hF;
    clearImg();
    for (int a = 'h800; a < 'h810; a++) img[a] = pickData();
    for (int i = 0; i < 40; i++) begin
      x = 12'h800 + 12'($urandom_range(0, 15));
      case ($urandom_range(0, 9))
        0, 9: img[i] = ins(4'h1, x);
        1: img[i] = ins(4'h2, x);
        2: img[i] = ins(4'h3, x);
        3: img[i] = ins(4'h4, x);
        4: img[i] = ins(4'hA, x);
        5: img[i] = ins(4'hB, x);
        6: img[i] = ins(4'hD, x);
        7: img[i] = ins(4'h8, {2'($urandom_range(0, 3)), 10'd0});
        default: img[i] = ins(nopCodes[$urandom_range(0, 4)], x);
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));

    // R1: reset state and preload/peek path
    repeat (3) @(negedge clk);
    check("R1", "reset pc", {4'd0, pcOut}, 16'd0);
    check("R1", "reset ac", acOut, 16'd0);
    check("R1", "reset halted", {15'd0, halted}, 16'd0);
    clearImg();
    img['h800] = 16'hBEEF;
    loadRange('h800, 1);
    peekAddr = 12'h800;
    #1;
    check("R1", "preload peek", peekData, 16'hBEEF);

    // R9: lone halt
    clearImg();
    runProg("R9");
    check("R9", "pc after lone halt", {4'd0, pcOut}, 16'd1);

    // R3: add/sub wrap
    clearImg();
    img[0] = ins(4'h1, 12'h801); img[1] = ins(4'h3, 12'h802);
    img[2] = ins(4'h4, 12'h803); img[3] = ins(4'h2, 12'h804);
    img['h801] = 16'h7FFF; img['h802] = 16'h0001; img['h803] = 16'hFFFF;
    runProg("R3");
    check("R3", "add/sub wrap", acOut, 16'h8001);

    // R4: store and clear
    clearImg();
    img[0] = ins(4'h1, 12'h801); img[1] = ins(4'h2, 12'h809);
    img[2] = ins(4'hA, 12'h000); img[3] = ins(4'h2, 12'h80A);
    img['h801] = 16'h1357; img['h80A] = 16'hAAAA;
    runProg("R4");
    check("R4", "cleared ac", acOut, 16'h0000);

    // R5 and R2: jump over clears onto an unused code
    clearImg();
    img[0] = ins(4'h9, 12'h00A);
    for (int i = 1; i < 10; i++) img[i] = ins(4'hA, 12'h000);
    img[10] = ins(4'h5, 12'h123); img[11] = ins(4'h1, 12'h801);
    img['h801] = 16'h4242;
    runProg("R5");
    check("R2", "nop then load", acOut, 16'h4242);

    // R6: increment in place with wrap
    clearImg();
    img[0] = ins(4'h1, 12'h801); img[1] = ins(4'hB, 12'h800);
    img[2] = ins(4'hB, 12'h802);
    img['h800] = 16'hFFFF; img['h801] = 16'h0005; img['h802] = 16'h7FFF;
    runProg("R6");
    peekAddr = 12'h800; #1;
    check("R6", "inc wrap", peekData, 16'h0000);
    check("R6", "ac untouched", acOut, 16'h0005);

    // R7: add-to-PC with a negative datum wraps below zero
    clearImg();
    img[0] = ins(4'hC, 12'h800);
    img['h800] = 16'hFFFE;
    runProg("R7");
    check("R7", "pc wrapped past top", {4'd0, pcOut}, 16'h0000);

    // R7: forward add-to-PC skips clears
    clearImg();
    img[0] = ins(4'h1, 12'h801); img[1] = ins(4'hC, 12'h800);
    for (int i = 2; i < 5; i++) img[i] = ins(4'hA, 12'h000);
    img['h800] = 16'h0003; img['h801] = 16'h0077;
    runProg("R7");
    check("R7", "forward target", {4'd0, pcOut}, 16'h0006);

    // R8: clear-if-positive across 0, 0x8000, 1, 0x7FFF
    clearImg();
    img[0] = ins(4'h1, 12'h801); img[1] = ins(4'hD, 12'h804);
    img[2] = ins(4'h1, 12'h802); img[3] = ins(4'hD, 12'h805);
    img[4] = ins(4'h1, 12'h803); img[5] = ins(4'hD, 12'h806);
    img[6] = ins(4'h1, 12'h807); img[7] = ins(4'hD, 12'h808);
    img['h801] = 16'h0000; img['h802] = 16'h8000; img['h803] = 16'h0001;
    img['h807] = 16'h7FFF;
    for (int a = 'h804; a < 'h807; a++) img[a] = 16'h1234;
    img['h808] = 16'h1234;
    runProg("R8");
    peekAddr = 12'h804; #1; check("R8", "ac zero keeps", peekData, 16'h1234);
    peekAddr = 12'h805; #1; check("R8", "ac negative keeps", peekData, 16'h1234);
    peekAddr = 12'h806; #1; check("R8", "ac one clears", peekData, 16'h0000);

    // R10: each skip selector, taken and not taken
    clearImg();
    img[0] = ins(4'h1, 12'h801); img[1] = ins(4'h8, 12'h400);
    img[2] = ins(4'hB, 12'h80A); img[3] = ins(4'h8, 12'h000);
    img[4] = ins(4'hB, 12'h80B); img[5] = ins(4'h1, 12'h802);
    img[6] = ins(4'h8, 12'h000); img[7] = ins(4'hB, 12'h80C);
    img[8] = ins(4'h8, 12'h800); img[9] = ins(4'hB, 12'h80D);
    img[10] = ins(4'h8, 12'hC00); img[11] = ins(4'hB, 12'h80E);
    img[12] = ins(4'h1, 12'h803); img[13] = ins(4'h8, 12'h800);
    img[14] = ins(4'hB, 12'h80F);
    img['h801] = 16'h0000; img['h802] = 16'hFFF0; img['h803] = 16'h0009;
    runProg("R10");
    peekAddr = 12'h80A; #1; check("R10", "zero skip taken", peekData, 16'h0000);
    peekAddr = 12'h80F; #1; check("R10", "positive skip taken", peekData, 16'h0000);

    // R2/R3/R4/R6/R8/R10: random instruction mixes
    for (int r = 0; r < 12; r++) begin
      genRandom();
      runProg("R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule